// File: doc/BRIEF.md
# Static Branch Direction and Target Unit

This front-end unit turns a fetched branch into a prediction in the same cycle that the branch is presented. It takes the branch address, a signed 21-bit word displacement, a flag that marks the branch as unconditional, and the number of the register that receives the return address. From these it produces the predicted target, the predicted direction and, for unconditional branches, a link write that carries the address of the next instruction. No history is kept. A conditional branch that points backward is predicted taken, and one that points forward or to zero displacement is predicted not taken.

Each issued branch is stored in a slot chosen by a caller-supplied 2-bit tag, so up to four branches can wait for resolution at once. When the execute stage returns the actual direction of a branch under its tag, the unit compares it with the stored prediction. On the next clock edge it raises a mispredict pulse with the corrected next address and the tag. The slot is then freed. Fetch, caches and flush control sit outside the block.

Top module: `brpred_static_top`

## Requirements
- R1: In the cycle a branch is issued, `pred_target` equals `issue_pc + 4 + 4 * sign_extend(issue_disp)`, computed modulo 2^PC_W. Bit 20 of `issue_disp` is the sign bit.
- R2: A conditional branch (`issue_uncond` = 0) whose displacement has bit 20 set is predicted taken (`pred_taken` = 1) in the same cycle.
- R3: A conditional branch whose displacement has bit 20 clear, zero included, is predicted not taken (`pred_taken` = 0).
- R4: An unconditional branch (`issue_uncond` = 1) is predicted taken. In the same cycle it asserts `link_we`, with `link_value` = `issue_pc + 4` and `link_reg` = `issue_link_reg`, and this holds for register number 0 as well.
- R5: A conditional branch never asserts `link_we`.
- R6: One clock edge after `res_valid` is seen for an outstanding conditional branch, `mis_valid` is 1 exactly when `res_taken` differs from the prediction. When it is 1, `mis_pc` is the target if `res_taken` = 1 and the branch address + 4 otherwise, and `mis_tag` equals the resolved tag.
- R7: Resolving an unconditional branch never raises `mis_valid`, whatever `res_taken` is.
- R8: A resolution frees its slot. A resolution whose tag is not outstanding, either because it was never issued since reset or because it was already resolved, raises no mispredict.
- R9: The four slots are independent, and outstanding branches may be resolved in any order.
- R10: After reset no slot is outstanding and `mis_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A branch is presented for prediction this cycle |
| issue_tag | input | TAG_W | Slot the branch occupies until resolved |
| issue_pc | input | PC_W | Address of the branch instruction |
| issue_disp | input | DISP_W | Signed displacement in 4-byte units |
| issue_uncond | input | 1 | 1 = unconditional branch |
| issue_link_reg | input | REG_W | Register receiving the return address |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | PC_W | Predicted target address |
| link_we | output | 1 | Link register write enable |
| link_reg | output | REG_W | Link register number |
| link_value | output | PC_W | Return address to write |
| res_valid | input | 1 | Execute stage reports a resolved branch |
| res_tag | input | TAG_W | Tag of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| mis_valid | output | 1 | Mispredict pulse, one cycle |
| mis_pc | output | PC_W | Corrected next address |
| mis_tag | output | TAG_W | Tag of the mispredicted branch |

## Verification
Prediction and link outputs are combinational. The bench drives a branch on the falling edge and samples these outputs one nanosecond later, before the rising edge that stores the branch in its slot. The mispredict outputs are registered, so they are due exactly one rising edge after the resolution is presented. The bench drives a resolution on a falling edge, drops it on the next falling edge and samples the mispredict outputs there. Because each resolution comes at least one edge after its issue, the slot contents are always settled when they are looked up.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

   // Static class of a stored branch; the class alone fixes the prediction.
   typedef enum logic [1:0] {
      BK_COND_FWD = 2'd0,
      BK_COND_BWD = 2'd1,
      BK_UNCOND   = 2'd2
   } br_kind_e;

   function automatic logic kind_predicts_taken(input br_kind_e k);
      return (k != BK_COND_FWD);
   endfunction

   function automatic logic kind_can_mispredict(input br_kind_e k);
      return (k != BK_UNCOND);
   endfunction

endpackage

// File: rtl/brpred_target_calc.sv
module brpred_target_calc
   import brpred_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int DISP_W = 21,
   parameter int REG_W  = 5
) (
   input  logic              valid,
   input  logic [PC_W-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   input  logic              uncond,
   input  logic [REG_W-1:0]  link_reg_in,
   output br_kind_e          kind,
   output logic [PC_W-1:0]   fallthru,
   output logic [PC_W-1:0]   target,
   output logic              pred_taken,
   output logic              link_we,
   output logic [REG_W-1:0]  link_reg,
   output logic [PC_W-1:0]   link_value
);
   localparam int EXT_W = PC_W - DISP_W;

   logic [PC_W-1:0] disp_ext;
   logic [PC_W-1:0] byte_off;

   always_comb begin
      disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      byte_off = {disp_ext[PC_W-3:0], 2'b00};
      fallthru = pc + PC_W'(4);
      target   = fallthru + byte_off;
      if (uncond)                kind = BK_UNCOND;
      else if (disp[DISP_W-1])   kind = BK_COND_BWD;
      else                       kind = BK_COND_FWD;
      pred_taken = valid && kind_predicts_taken(kind);
      link_we    = valid && uncond;
      link_reg   = link_reg_in;
      link_value = fallthru;
   end

endmodule

// File: rtl/brpred_slot_queue.sv
module brpred_slot_queue
   import brpred_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int TAG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  br_kind_e         wr_kind,
   input  logic [PC_W-1:0]  wr_target,
   input  logic [PC_W-1:0]  wr_fallthru,
   input  logic             clr_en,
   input  logic [TAG_W-1:0] clr_tag,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   output br_kind_e         rd_kind,
   output logic [PC_W-1:0]  rd_target,
   output logic [PC_W-1:0]  rd_fallthru
);
   localparam int DEPTH = 1 << TAG_W;

   logic [DEPTH-1:0] slot_v;
   br_kind_e         slot_kind [DEPTH];
   logic [PC_W-1:0]  slot_tgt  [DEPTH];
   logic [PC_W-1:0]  slot_ft   [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic            v_q;
      br_kind_e        kind_q;
      logic [PC_W-1:0] tgt_q;
      logic [PC_W-1:0] ft_q;
      logic            hit_wr;
      logic            hit_clr;

      assign hit_wr  = wr_en  && (wr_tag  == TAG_W'(g));
      assign hit_clr = clr_en && (clr_tag == TAG_W'(g));

      // A new issue into a slot wins over a same-cycle clear of that slot.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            kind_q <= BK_COND_FWD;
            tgt_q  <= '0;
            ft_q   <= '0;
         end else if (hit_wr) begin
            v_q    <= 1'b1;
            kind_q <= wr_kind;
            tgt_q  <= wr_target;
            ft_q   <= wr_fallthru;
         end else if (hit_clr) begin
            v_q    <= 1'b0;
         end
      end

      assign slot_v[g]    = v_q;
      assign slot_kind[g] = kind_q;
      assign slot_tgt[g]  = tgt_q;
      assign slot_ft[g]   = ft_q;
   end

   assign rd_valid    = slot_v[rd_tag];
   assign rd_kind     = slot_kind[rd_tag];
   assign rd_target   = slot_tgt[rd_tag];
   assign rd_fallthru = slot_ft[rd_tag];

endmodule

// File: rtl/brpred_resolve.sv
module brpred_resolve
   import brpred_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int TAG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   input  logic [TAG_W-1:0] res_tag,
   input  logic             res_taken,
   input  logic             slot_valid,
   input  br_kind_e         slot_kind,
   input  logic [PC_W-1:0]  slot_target,
   input  logic [PC_W-1:0]  slot_fallthru,
   output logic             clr_en,
   output logic             mis_valid,
   output logic [PC_W-1:0]  mis_pc,
   output logic [TAG_W-1:0] mis_tag
);
   logic hit;
   logic wrong;

   assign hit    = res_valid && slot_valid;
   assign wrong  = hit && kind_can_mispredict(slot_kind)
                   && (res_taken != kind_predicts_taken(slot_kind));
   assign clr_en = hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mis_valid <= 1'b0;
         mis_pc    <= '0;
         mis_tag   <= '0;
      end else begin
         mis_valid <= wrong;
         if (wrong) begin
            mis_pc  <= res_taken ? slot_target : slot_fallthru;
            mis_tag <= res_tag;
         end
      end
   end

endmodule

// File: rtl/brpred_static_top.sv
module brpred_static_top
   import brpred_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int DISP_W = 21,
   parameter int REG_W  = 5,
   parameter int TAG_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [TAG_W-1:0]  issue_tag,
   input  logic [PC_W-1:0]   issue_pc,
   input  logic [DISP_W-1:0] issue_disp,
   input  logic              issue_uncond,
   input  logic [REG_W-1:0]  issue_link_reg,
   output logic              pred_taken,
   output logic [PC_W-1:0]   pred_target,
   output logic              link_we,
   output logic [REG_W-1:0]  link_reg,
   output logic [PC_W-1:0]   link_value,
   input  logic              res_valid,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic              res_taken,
   output logic              mis_valid,
   output logic [PC_W-1:0]   mis_pc,
   output logic [TAG_W-1:0]  mis_tag
);
   if (DISP_W < 2 || DISP_W + 2 > PC_W) begin : g_bad_disp
      $error("brpred_static_top: DISP_W must be at least 2 and at most PC_W-2");
   end
   if (TAG_W < 1 || TAG_W > 6) begin : g_bad_tag
      $error("brpred_static_top: TAG_W must lie in 1..6");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("brpred_static_top: REG_W must be positive");
   end

   br_kind_e        new_kind;
   logic [PC_W-1:0] new_ft;
   logic [PC_W-1:0] new_tgt;
   logic            q_valid;
   br_kind_e        q_kind;
   logic [PC_W-1:0] q_tgt;
   logic [PC_W-1:0] q_ft;
   logic            clr_en;

   brpred_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W), .REG_W(REG_W)) calc_i (
      .valid       (issue_valid),
      .pc          (issue_pc),
      .disp        (issue_disp),
      .uncond      (issue_uncond),
      .link_reg_in (issue_link_reg),
      .kind        (new_kind),
      .fallthru    (new_ft),
      .target      (new_tgt),
      .pred_taken  (pred_taken),
      .link_we     (link_we),
      .link_reg    (link_reg),
      .link_value  (link_value)
   );

   assign pred_target = new_tgt;

   brpred_slot_queue #(.PC_W(PC_W), .TAG_W(TAG_W)) queue_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (issue_valid),
      .wr_tag      (issue_tag),
      .wr_kind     (new_kind),
      .wr_target   (new_tgt),
      .wr_fallthru (new_ft),
      .clr_en      (clr_en),
      .clr_tag     (res_tag),
      .rd_tag      (res_tag),
      .rd_valid    (q_valid),
      .rd_kind     (q_kind),
      .rd_target   (q_tgt),
      .rd_fallthru (q_ft)
   );

   brpred_resolve #(.PC_W(PC_W), .TAG_W(TAG_W)) resolve_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .res_valid     (res_valid),
      .res_tag       (res_tag),
      .res_taken     (res_taken),
      .slot_valid    (q_valid),
      .slot_kind     (q_kind),
      .slot_target   (q_tgt),
      .slot_fallthru (q_ft),
      .clr_en        (clr_en),
      .mis_valid     (mis_valid),
      .mis_pc        (mis_pc),
      .mis_tag       (mis_tag)
   );

endmodule

// File: rtl/brpred_static_chk.sv
module brpred_static_chk #(
   parameter int PC_W   = 32,
   parameter int DISP_W = 21,
   parameter int REG_W  = 5,
   parameter int TAG_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic [DISP_W-1:0] issue_disp,
   input logic              issue_uncond,
   input logic [REG_W-1:0]  issue_link_reg,
   input logic              pred_taken,
   input logic              link_we,
   input logic [REG_W-1:0]  link_reg,
   input logic              res_valid,
   input logic [TAG_W-1:0]  res_tag,
   input logic              mis_valid,
   input logic [TAG_W-1:0]  mis_tag
);
   p_bwd_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_uncond && issue_disp[DISP_W-1]) |-> pred_taken);

   p_fwd_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_uncond && !issue_disp[DISP_W-1]) |-> !pred_taken);

   p_uncond_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_uncond) |-> (pred_taken && link_we && link_reg == issue_link_reg));

   p_cond_no_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_uncond) |-> !link_we);

   p_mis_follows_res_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mis_valid |-> ($past(res_valid) && mis_tag == $past(res_tag)));

   p_quiet_without_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> !mis_valid);

   p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !mis_valid);

endmodule

bind brpred_static_top brpred_static_chk #(
   .PC_W(PC_W), .DISP_W(DISP_W), .REG_W(REG_W), .TAG_W(TAG_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .issue_valid    (issue_valid),
   .issue_disp     (issue_disp),
   .issue_uncond   (issue_uncond),
   .issue_link_reg (issue_link_reg),
   .pred_taken     (pred_taken),
   .link_we        (link_we),
   .link_reg       (link_reg),
   .res_valid      (res_valid),
   .res_tag        (res_tag),
   .mis_valid      (mis_valid),
   .mis_tag        (mis_tag)
);

// File: tb/brpred_static_tb.sv
`timescale 1ns/1ps
module brpred_static_top_tb_top;
   localparam int PC_W   = 32;
   localparam int DISP_W = 21;
   localparam int REG_W  = 5;
   localparam int TAG_W  = 2;

   typedef struct packed {
      logic [31:0] pc;
      logic [20:0] disp;
      logic        unc;
      logic [4:0]  lr;
      logic        act;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_1000, 21'h1FFFFC, 1'b0, 5'd0,  1'b1},
      '{32'h0000_2000, 21'h000010, 1'b0, 5'd3,  1'b1},
      '{32'h0000_3000, 21'h000000, 1'b0, 5'd7,  1'b0},
      '{32'h0000_4000, 21'h1FFFFF, 1'b0, 5'd1,  1'b0},
      '{32'h0000_5000, 21'h0FFFFF, 1'b1, 5'd26, 1'b1},
      '{32'h0000_6000, 21'h100000, 1'b1, 5'd0,  1'b0},
      '{32'hFFFF_FFF8, 21'h000002, 1'b0, 5'd9,  1'b1},
      '{32'h0000_0004, 21'h1FFFFE, 1'b0, 5'd2,  1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              issue_valid = 1'b0;
   logic [TAG_W-1:0]  issue_tag = '0;
   logic [PC_W-1:0]   issue_pc = '0;
   logic [DISP_W-1:0] issue_disp = '0;
   logic              issue_uncond = 1'b0;
   logic [REG_W-1:0]  issue_link_reg = '0;
   logic              pred_taken;
   logic [PC_W-1:0]   pred_target;
   logic              link_we;
   logic [REG_W-1:0]  link_reg;
   logic [PC_W-1:0]   link_value;
   logic              res_valid = 1'b0;
   logic [TAG_W-1:0]  res_tag = '0;
   logic              res_taken = 1'b0;
   logic              mis_valid;
   logic [PC_W-1:0]   mis_pc;
   logic [TAG_W-1:0]  mis_tag;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   brpred_static_top #(.PC_W(PC_W), .DISP_W(DISP_W), .REG_W(REG_W), .TAG_W(TAG_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_pc(issue_pc),
      .issue_disp(issue_disp), .issue_uncond(issue_uncond), .issue_link_reg(issue_link_reg),
      .pred_taken(pred_taken), .pred_target(pred_target), .link_we(link_we),
      .link_reg(link_reg), .link_value(link_value),
      .res_valid(res_valid), .res_tag(res_tag), .res_taken(res_taken),
      .mis_valid(mis_valid), .mis_pc(mis_pc), .mis_tag(mis_tag)
   );

   function automatic logic [31:0] m_target(input logic [31:0] pc, input logic [20:0] d);
      return pc + 32'd4 + ({{11{d[20]}}, d} * 32'd4);
   endfunction

   function automatic logic m_pred(input logic unc, input logic [20:0] d);
      return unc || d[20];
   endfunction

   task automatic check(input logic ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive a branch on the falling edge, check the same-cycle prediction.
   task automatic do_issue(input logic [31:0] pc, input logic [20:0] d, input logic unc,
                           input logic [4:0] lr, input logic [1:0] tag);
      @(negedge clk);
      issue_valid = 1'b1; issue_pc = pc; issue_disp = d;
      issue_uncond = unc; issue_link_reg = lr; issue_tag = tag;
      #1;
      check(pred_target == m_target(pc, d), "R1", "target", pred_target, m_target(pc, d));
      check(pred_taken == m_pred(unc, d), unc ? "R4" : (d[20] ? "R2" : "R3"),
            "direction", 32'(pred_taken), 32'(m_pred(unc, d)));
      if (unc) begin
         check(link_we && link_value == pc + 32'd4 && link_reg == lr, "R4", "link",
               link_value, pc + 32'd4);
      end else begin
         check(!link_we, "R5", "link_we", 32'(link_we), 32'd0);
      end
      @(posedge clk);
      #1 issue_valid = 1'b0;
   endtask

   // Present a resolution for one cycle, check the registered outcome.
   task automatic do_resolve(input logic [1:0] tag, input logic taken,
                             input logic exp_mis, input logic [31:0] exp_pc, input string req);
      @(negedge clk);
      res_valid = 1'b1; res_tag = tag; res_taken = taken;
      @(negedge clk);
      res_valid = 1'b0;
      check(mis_valid == exp_mis, req, "mis_valid", 32'(mis_valid), 32'(exp_mis));
      if (exp_mis) begin
         check(mis_pc == exp_pc, req, "mis_pc", mis_pc, exp_pc);
         check(mis_tag == tag, req, "mis_tag", 32'(mis_tag), 32'(tag));
      end
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!mis_valid, "R10", "mis_valid after reset", 32'(mis_valid), 32'd0);
      // R10/R8: no slot outstanding after reset
      do_resolve(2'd3, 1'b1, 1'b0, 32'd0, "R10");
      do_resolve(2'd0, 1'b0, 1'b0, 32'd0, "R8");

      // Table walk: R1 R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         vec_t v = VECS[i];
         logic [1:0] tg = 2'(i % 4);
         logic mis = !v.unc && (v.act != v.disp[20]);
         logic [31:0] mpc = v.act ? m_target(v.pc, v.disp) : v.pc + 32'd4;
         do_issue(v.pc, v.disp, v.unc, v.lr, tg);
         do_resolve(tg, v.act, mis, mpc, v.unc ? "R7" : "R6");
      end

      // R8: a second resolution of the same tag is ignored
      do_issue(32'h0000_8000, 21'h000020, 1'b0, 5'd4, 2'd1);
      do_resolve(2'd1, 1'b1, 1'b1, 32'h0000_8084, "R6");
      do_resolve(2'd1, 1'b1, 1'b0, 32'd0, "R8");

      // R9: four outstanding, resolved out of order
      do_issue(32'h0001_0000, 21'h000008, 1'b0, 5'd0, 2'd0);
      do_issue(32'h0002_0000, 21'h1FFFF0, 1'b0, 5'd0, 2'd1);
      do_issue(32'h0003_0000, 21'h000100, 1'b0, 5'd0, 2'd2);
      do_issue(32'h0004_0000, 21'h000001, 1'b1, 5'd0, 2'd3);
      do_resolve(2'd2, 1'b1, 1'b1, 32'h0003_0404, "R9");
      do_resolve(2'd0, 1'b0, 1'b0, 32'd0,         "R9");
      do_resolve(2'd3, 1'b0, 1'b0, 32'd0,         "R9");
      do_resolve(2'd1, 1'b0, 1'b1, 32'h0002_0004, "R9");

      // R3: zero displacement predicted not taken, taken outcome lands on pc+4 target
      do_issue(32'h0000_A000, 21'h000000, 1'b0, 5'd0, 2'd2);
      do_resolve(2'd2, 1'b1, 1'b1, 32'h0000_A004, "R3");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule